// File: doc/BRIEF.md
# Dual-Buffer Instruction Prefetcher

This block sits between a core's fetch stage and its instruction cache. It keeps two fetch-line buffers. For each valid fetch PC it rounds the PC down to a line boundary and decides which buffer serves that line. If neither buffer holds the line, buffer 1 takes it. The other buffer is then made to hold the following line. Every buffer that takes a new line issues a load request to the cache on its own request lane, and each request carries a unique tag from a shared counter.

The block raises a stall for as long as the serving buffer is waiting for its data. A branch penalty can be loaded beforehand. It adds stall cycles to the first fetch of a bundle and then clears. When the cache is disabled and cycle counting is off, the block issues no requests and never stalls.

Top module: `ifetch_dualbuf`

## Requirements
- R1: After reset neither buffer holds a line and none has a request outstanding. The first valid fetch therefore issues requests on both lanes, and the first tag issued is 0x80000000.
- R2: The address of every request is the fetch PC with its low log2(LINE_BYTES) bits cleared. LINE_BYTES is 16 by default and may be 8.
- R3: If buffer 0 holds the line of the current PC, buffer 0 serves the fetch. Otherwise, if buffer 1 holds it, buffer 1 serves. Otherwise buffer 1 serves and loads the line. Lane i (bit i of reqValid, slice i of reqAddr and reqTag) always belongs to buffer i.
- R4: When the serving buffer does not hold the current line, it takes that line in the same cycle and issues a request on its lane with a fresh tag.
- R5: The buffer that does not serve is made to hold current line + LINE_BYTES. It issues a request only if it does not already hold exactly that line.
- R6: Tags come from one counter that advances by one per request. When both lanes request in one cycle, the serving buffer's lane gets the lower tag. The value 0 is reserved as "no request" and is skipped.
- R7: stall is high for a valid, active fetch while the serving buffer must load or still has a request outstanding. A response with the matching tag marks the buffer filled, and stall falls in the cycle after the response.
- R8: A response whose tag matches neither buffer's outstanding request changes nothing, and the stall stays high.
- R9: Pulsing penLoad with value N arms an N-cycle penalty. Only valid fetches with firstSlot=1 consume it, one cycle per cycle, and stall is high during those cycles even on a line hit. Fetches with firstSlot=0 leave the penalty untouched.
- R10: With cacheEn=0 and cycleCount=0 no request is issued, stall is low, and neither buffer contents nor the armed penalty change.
- R11: If a response for a buffer's old tag arrives in the same cycle that the buffer takes a new line, the new request stays outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pcValid | input | 1 | Fetch PC is valid this cycle |
| pcIn | input | ADDR_W | Fetch PC (byte address) |
| firstSlot | input | 1 | Fetch is the first instruction of a bundle |
| cacheEn | input | 1 | Instruction cache enabled |
| cycleCount | input | 1 | Cycle counting enabled |
| penLoad | input | 1 | Arm a branch penalty |
| penCycles | input | PEN_W | Penalty length in cycles |
| rspValid | input | 1 | Cache response valid |
| rspTag | input | 32 | Tag of the completed request |
| stall | output | 1 | Hold the fetch PC |
| reqValid | output | 2 | Request strobe per buffer lane |
| reqAddr | output | 2*ADDR_W | Line address per lane |
| reqTag | output | 64 | Request tag per lane |

## Verification
Two events can fall on the same buffer in one cycle: the buffer is reloaded with a new line, and the cache response for its previous tag arrives. The bench provokes this directly. It leaves buffer 1's prefetch unanswered, jumps to an unrelated PC so that buffer 1 reloads, and returns the old tag in that same cycle. The coincidence is judged correct when the stall stays high in the following cycles until the new tag is answered. Random runs also let stale responses land on reloading buffers, and every cycle is compared against a reference model written from the requirements.

// File: rtl/ifp_pkg.sv
package ifp_pkg;
  localparam int TAG_W = 32;
  localparam logic [TAG_W-1:0] NO_REQ_TAG = '0;

  typedef struct packed {
    logic [1:0] load;    // buffer i takes a new line this cycle
    logic       curIdx;  // buffer serving the fetch
  } ifpStrobe_t;

  function automatic logic [TAG_W-1:0] nextTag(input logic [TAG_W-1:0] t);
    logic [TAG_W-1:0] n;
    n = t + 1'b1;
    if (n == NO_REQ_TAG) n = n + 1'b1;
    return n;
  endfunction
endpackage

// File: rtl/ifp_ctrl.sv
module ifp_ctrl
  import ifp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int PEN_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pcValid,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic              firstSlot,
  input  logic              cacheEn,
  input  logic              cycleCount,
  input  logic              penLoad,
  input  logic [PEN_W-1:0]  penCycles,
  input  logic [1:0]        bufValid,
  input  logic [2*ADDR_W-1:0] bufAddr,
  input  logic [1:0]        bufPend,
  output ifpStrobe_t        strobe,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] preAddr,
  output logic              stall
);
  localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);

  logic             go;
  logic [1:0]       holdCur;
  logic [1:0]       holdPre;
  logic             curIdx;
  logic             preIdx;
  logic             loadCur;
  logic             loadPre;
  logic             penBusy;
  logic [PEN_W-1:0] penCnt;

  assign go      = (cacheEn | cycleCount) & pcValid;
  assign curAddr = pcIn & ~LINE_MASK;
  assign preAddr = curAddr + ADDR_W'(LINE_BYTES);

  for (genvar i = 0; i < 2; i++) begin : g_cmp
    assign holdCur[i] = bufValid[i] && (bufAddr[i*ADDR_W +: ADDR_W] == curAddr);
    assign holdPre[i] = bufValid[i] && (bufAddr[i*ADDR_W +: ADDR_W] == preAddr);
  end

  // buffer 0 wins a match; a miss falls to buffer 1
  assign curIdx  = holdCur[0] ? 1'b0 : 1'b1;
  assign preIdx  = ~curIdx;
  assign loadCur = go & ~holdCur[curIdx];
  assign loadPre = go & ~holdPre[preIdx];

  always_comb begin
    strobe.curIdx = curIdx;
    strobe.load   = 2'b00;
    strobe.load[curIdx] = loadCur;
    strobe.load[preIdx] = loadPre;
  end

  assign penBusy = firstSlot && (penCnt != '0);
  assign stall   = go & (loadCur | bufPend[curIdx] | penBusy);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      penCnt <= '0;
    end else if (penLoad) begin
      penCnt <= penCycles;
    end else if (go && penBusy) begin
      penCnt <= penCnt - 1'b1;
    end
  end
endmodule

// File: rtl/ifp_datapath.sv
module ifp_datapath
  import ifp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [TAG_W-1:0] RESET_TAG = 32'h8000_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ifpStrobe_t          strobe,
  input  logic [ADDR_W-1:0]   curAddr,
  input  logic [ADDR_W-1:0]   preAddr,
  input  logic                rspValid,
  input  logic [TAG_W-1:0]    rspTag,
  output logic [1:0]          bufValid,
  output logic [2*ADDR_W-1:0] bufAddr,
  output logic [1:0]          bufPend,
  output logic [1:0]          reqValid,
  output logic [2*ADDR_W-1:0] reqAddr,
  output logic [2*TAG_W-1:0]  reqTag
);
  logic [TAG_W-1:0] tagCnt;
  logic [TAG_W-1:0] tagB;
  logic [TAG_W-1:0] tagC;

  assign tagB = nextTag(tagCnt);
  assign tagC = nextTag(tagB);

  for (genvar i = 0; i < 2; i++) begin : g_buf
    logic              isCur;
    logic [ADDR_W-1:0] newAddr;
    logic [TAG_W-1:0]  newTag;
    logic [ADDR_W-1:0] addrQ;
    logic [TAG_W-1:0]  tagQ;
    logic              validQ;
    logic              rspHit;

    assign isCur   = (strobe.curIdx == 1'(i));
    assign newAddr = isCur ? curAddr : preAddr;
    // serving lane takes the lower tag when both lanes request
    assign newTag  = (isCur || !strobe.load[strobe.curIdx]) ? tagCnt : tagB;
    assign rspHit  = rspValid && (tagQ != NO_REQ_TAG) && (rspTag == tagQ);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        validQ <= 1'b0;
        addrQ  <= '0;
        tagQ   <= NO_REQ_TAG;
      end else if (strobe.load[i]) begin
        validQ <= 1'b1;
        addrQ  <= newAddr;
        tagQ   <= newTag;
      end else if (rspHit) begin
        tagQ   <= NO_REQ_TAG;
      end
    end

    assign bufValid[i]                 = validQ;
    assign bufAddr[i*ADDR_W +: ADDR_W] = addrQ;
    assign bufPend[i]                  = (tagQ != NO_REQ_TAG);
    assign reqValid[i]                 = strobe.load[i];
    assign reqAddr[i*ADDR_W +: ADDR_W] = newAddr;
    assign reqTag[i*TAG_W +: TAG_W]    = newTag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tagCnt <= RESET_TAG;
    end else begin
      case (strobe.load)
        2'b00:   tagCnt <= tagCnt;
        2'b11:   tagCnt <= tagC;
        default: tagCnt <= tagB;
      endcase
    end
  end
endmodule

// File: rtl/ifetch_dualbuf.sv
module ifetch_dualbuf
  import ifp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int PEN_W      = 4,
  parameter logic [31:0] RESET_TAG = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pcValid,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic              firstSlot,
  input  logic              cacheEn,
  input  logic              cycleCount,
  input  logic              penLoad,
  input  logic [PEN_W-1:0]  penCycles,
  input  logic              rspValid,
  input  logic [31:0]       rspTag,
  output logic              stall,
  output logic [1:0]        reqValid,
  output logic [2*ADDR_W-1:0] reqAddr,
  output logic [63:0]       reqTag
);
  ifpStrobe_t          strobe;
  logic [ADDR_W-1:0]   curAddr;
  logic [ADDR_W-1:0]   preAddr;
  logic [1:0]          bufValid;
  logic [2*ADDR_W-1:0] bufAddr;
  logic [1:0]          bufPend;

  ifp_ctrl #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .PEN_W(PEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pcValid(pcValid), .pcIn(pcIn),
    .firstSlot(firstSlot), .cacheEn(cacheEn), .cycleCount(cycleCount),
    .penLoad(penLoad), .penCycles(penCycles), .bufValid(bufValid),
    .bufAddr(bufAddr), .bufPend(bufPend), .strobe(strobe),
    .curAddr(curAddr), .preAddr(preAddr), .stall(stall)
  );

  ifp_datapath #(.ADDR_W(ADDR_W), .RESET_TAG(RESET_TAG)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .curAddr(curAddr),
    .preAddr(preAddr), .rspValid(rspValid), .rspTag(rspTag),
    .bufValid(bufValid), .bufAddr(bufAddr), .bufPend(bufPend),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqTag(reqTag)
  );
endmodule

// File: rtl/ifetch_dualbuf_chk.sv
module ifetch_dualbuf_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pcValid,
  input logic                cacheEn,
  input logic                cycleCount,
  input logic                stall,
  input logic [1:0]          reqValid,
  input logic [2*ADDR_W-1:0] reqAddr,
  input logic [63:0]         reqTag
);
  localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);
  localparam logic [ADDR_W-1:0] LINE_STEP = ADDR_W'(LINE_BYTES);

  // R10
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cacheEn && !cycleCount) |-> (reqValid == 2'b00 && !stall));

  // R3
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pcValid |-> (reqValid == 2'b00 && !stall));

  // R2
  lane0_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid[0] |-> ((reqAddr[ADDR_W-1:0] & LINE_MASK) == '0));

  // R2
  lane1_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid[1] |-> ((reqAddr[2*ADDR_W-1:ADDR_W] & LINE_MASK) == '0));

  // R5
  pair_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid == 2'b11) |->
      ((reqAddr[2*ADDR_W-1:ADDR_W] == reqAddr[ADDR_W-1:0] + LINE_STEP) ||
       (reqAddr[ADDR_W-1:0] == reqAddr[2*ADDR_W-1:ADDR_W] + LINE_STEP)));

  // R6
  lane0_tag_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid[0] |-> (reqTag[31:0] != 32'h0));

  // R6
  lane1_tag_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid[1] |-> (reqTag[63:32] != 32'h0));

  // R6
  pair_tag_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid == 2'b11) |-> (reqTag[31:0] != reqTag[63:32]));
endmodule

bind ifetch_dualbuf ifetch_dualbuf_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .pcValid(pcValid), .cacheEn(cacheEn),
  .cycleCount(cycleCount), .stall(stall), .reqValid(reqValid),
  .reqAddr(reqAddr), .reqTag(reqTag)
);

// File: tb/ifetch_dualbuf_bench.sv
`timescale 1ns/1ps
module ifetch_dualbuf_bench;
  localparam int LB = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pcValid = 1'b0;
  logic [31:0] pcIn = '0;
  logic        firstSlot = 1'b0;
  logic        cacheEn = 1'b1;
  logic        cycleCount = 1'b0;
  logic        penLoad = 1'b0;
  logic [3:0]  penCycles = '0;
  logic        rspValid = 1'b0;
  logic [31:0] rspTag = '0;
  logic        stall, wStall;
  logic [1:0]  reqValid, wReqValid;
  logic [63:0] reqAddr, wReqAddr;
  logic [63:0] reqTag, wReqTag;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  ifetch_dualbuf u_ifetch_dualbuf (
    .clk(clk), .rst_n(rst_n), .pcValid(pcValid), .pcIn(pcIn),
    .firstSlot(firstSlot), .cacheEn(cacheEn), .cycleCount(cycleCount),
    .penLoad(penLoad), .penCycles(penCycles), .rspValid(rspValid),
    .rspTag(rspTag), .stall(stall), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqTag(reqTag)
  );

  ifetch_dualbuf #(.RESET_TAG(32'hFFFF_FFFE)) u_ifetch_dualbuf_wrap (
    .clk(clk), .rst_n(rst_n), .pcValid(pcValid), .pcIn(pcIn),
    .firstSlot(firstSlot), .cacheEn(cacheEn), .cycleCount(cycleCount),
    .penLoad(penLoad), .penCycles(penCycles), .rspValid(rspValid),
    .rspTag(rspTag), .stall(wStall), .reqValid(wReqValid),
    .reqAddr(wReqAddr), .reqTag(wReqTag)
  );

  // reference model state
  logic [31:0] mAddr [2];
  logic        mVal  [2];
  logic [31:0] mTag  [2];
  logic [31:0] mCnt;
  logic [3:0]  mPen;
  logic [1:0]  eLoad;
  logic [31:0] eAddr [2];
  logic [31:0] eTag  [2];
  logic        eStall;

  // cache model: outstanding tags
  logic [31:0] pendTag [16];
  int pendN = 0;

  function automatic logic [31:0] nt(input logic [31:0] t);
    logic [31:0] n;
    n = t + 1;
    if (n == 0) n = 1;
    return n;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 2; i++) begin
      mAddr[i] = '0; mVal[i] = 1'b0; mTag[i] = '0;
    end
    mCnt = 32'h8000_0000;
    mPen = '0;
  endtask

  task automatic push(input logic [31:0] t);
    if (pendN == 16) begin
      for (int k = 0; k < 15; k++) pendTag[k] = pendTag[k+1];
      pendN = 15;
    end
    pendTag[pendN] = t;
    pendN++;
  endtask

  task automatic step(input logic pv, input logic [31:0] pc, input logic fs,
                      input logic ce, input logic cc, input logic pl,
                      input logic [3:0] pcyc, input logic rv, input logic [31:0] rt);
    logic go, cur, pre;
    logic [31:0] al, pa, t;
    @(negedge clk);
    pcValid = pv; pcIn = pc; firstSlot = fs; cacheEn = ce; cycleCount = cc;
    penLoad = pl; penCycles = pcyc; rspValid = rv; rspTag = rt;
    #1;
    go  = (ce | cc) & pv;
    al  = pc & ~32'(LB - 1);
    pa  = al + LB;
    cur = (mVal[0] && mAddr[0] == al) ? 1'b0 : 1'b1;
    pre = ~cur;
    eLoad = 2'b00;
    eLoad[cur] = go && !(mVal[cur] && mAddr[cur] == al);
    eLoad[pre] = go && !(mVal[pre] && mAddr[pre] == pa);
    eAddr[cur] = al; eAddr[pre] = pa;
    t = mCnt;
    eTag[0] = t; eTag[1] = t;
    if (eLoad[cur]) begin eTag[cur] = t; t = nt(t); end
    eTag[pre] = t;
    if (eLoad[pre]) t = nt(t);
    eStall = go && (eLoad[cur] || mTag[cur] != 0 || (fs && mPen != 0));
    // model comparison every cycle
    chk("R3 reqValid", {62'd0, reqValid}, {62'd0, eLoad});
    for (int i = 0; i < 2; i++) begin
      if (eLoad[i]) begin
        chk("R2 reqAddr", {32'd0, reqAddr[i*32 +: 32]}, {32'd0, eAddr[i]});
        chk("R6 reqTag", {32'd0, reqTag[i*32 +: 32]}, {32'd0, eTag[i]});
        push(eTag[i]);
      end
    end
    chk("R7 stall", {63'd0, stall}, {63'd0, eStall});
    // model update
    for (int i = 0; i < 2; i++) begin
      if (rv && mTag[i] != 0 && mTag[i] == rt) mTag[i] = 0;
      if (eLoad[i]) begin
        mVal[i] = 1'b1; mAddr[i] = eAddr[i]; mTag[i] = eTag[i];
      end
    end
    mCnt = t;
    if (pl) mPen = pcyc;
    else if (go && fs && mPen != 0) mPen = mPen - 1;
  endtask

  task automatic fetch(input logic [31:0] pc, input logic fs);
    step(1'b1, pc, fs, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 32'd0);
  endtask

  task automatic fetchRsp(input logic [31:0] pc, input logic [31:0] rt);
    step(1'b1, pc, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b1, rt);
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pc;
    logic held;
    int r;
    r = $urandom(32'd2024);
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state, idle
    step(1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 32'd0);
    chk("R1 idle reqValid", {62'd0, reqValid}, 64'd0);
    chk("R1 idle stall", {63'd0, stall}, 64'd0);

    // R1 R2 R3 R6: first fetch misses both buffers
    fetch(32'h0000_1234, 1'b1);
    chk("R1 both lanes", {62'd0, reqValid}, 64'd3);
    chk("R3 lane1 serves", {32'd0, reqAddr[63:32]}, 64'h1230);
    chk("R5 lane0 next", {32'd0, reqAddr[31:0]}, 64'h1240);
    chk("R1 first tag", {32'd0, reqTag[63:32]}, 64'h8000_0000);
    chk("R6 second tag", {32'd0, reqTag[31:0]}, 64'h8000_0001);
    chk("R6 wrap lane1", {32'd0, wReqTag[63:32]}, 64'hFFFF_FFFE);
    chk("R6 wrap lane0", {32'd0, wReqTag[31:0]}, 64'hFFFF_FFFF);
    chk("R7 stall on miss", {63'd0, stall}, 64'd1);

    // R8: unmatched response
    fetchRsp(32'h0000_1234, 32'h0000_5555);
    fetch(32'h0000_1234, 1'b0);
    chk("R8 bogus ignored", {63'd0, stall}, 64'd1);

    // R7: matching response releases next cycle
    fetchRsp(32'h0000_1234, 32'h8000_0000);
    chk("R7 stall same cycle", {63'd0, stall}, 64'd1);
    fetch(32'h0000_1234, 1'b0);
    chk("R7 released", {63'd0, stall}, 64'd0);

    // R3 R5: move to line held by buffer 0
    fetch(32'h0000_1240, 1'b0);
    chk("R3 hit buf0 lanes", {62'd0, reqValid}, 64'd2);
    chk("R5 prefetch addr", {32'd0, reqAddr[63:32]}, 64'h1250);
    chk("R6 third tag", {32'd0, reqTag[63:32]}, 64'h8000_0002);
    chk("R6 reserved skipped", {32'd0, wReqTag[63:32]}, 64'h0000_0001);
    chk("R7 buf0 pending", {63'd0, stall}, 64'd1);
    fetchRsp(32'h0000_1240, 32'h8000_0001);
    fetch(32'h0000_1240, 1'b0);
    chk("R7 buf0 filled", {63'd0, stall}, 64'd0);

    // R9: penalty of 3 on first slot
    step(1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd3, 1'b0, 32'd0);
    for (int k = 0; k < 3; k++) begin
      fetch(32'h0000_1244, 1'b1);
      chk("R9 penalty stall", {63'd0, stall}, 64'd1);
    end
    fetch(32'h0000_1244, 1'b1);
    chk("R9 penalty cleared", {63'd0, stall}, 64'd0);

    // R9: firstSlot=0 does not consume
    step(1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd2, 1'b0, 32'd0);
    fetch(32'h0000_1248, 1'b0);
    chk("R9 non-first no stall", {63'd0, stall}, 64'd0);
    fetch(32'h0000_1248, 1'b0);
    fetch(32'h0000_1248, 1'b1);
    chk("R9 kept penalty", {63'd0, stall}, 64'd1);
    fetch(32'h0000_1248, 1'b1);
    fetch(32'h0000_1248, 1'b1);
    chk("R9 penalty done", {63'd0, stall}, 64'd0);

    // R10: inactive
    step(1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd1, 1'b0, 32'd0);
    step(1'b1, 32'h0000_9000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 32'd0);
    chk("R10 no requests", {62'd0, reqValid}, 64'd0);
    chk("R10 no stall", {63'd0, stall}, 64'd0);
    fetch(32'h0000_1248, 1'b0);
    chk("R10 buffers kept", {62'd0, reqValid}, 64'd0);
    fetch(32'h0000_1248, 1'b1);
    chk("R10 penalty kept", {63'd0, stall}, 64'd1);
    step(1'b1, 32'h0000_1248, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 32'd0);
    chk("R10 count-only active", {63'd0, stall}, 64'd0);

    // R4 R11: reload buffer 1 while its old tag returns
    fetchRsp(32'h0000_5004, 32'h8000_0002);
    chk("R4 reload lanes", {62'd0, reqValid}, 64'd3);
    chk("R4 fresh tag", {32'd0, reqTag[63:32]}, 64'h8000_0003);
    fetch(32'h0000_5004, 1'b0);
    chk("R11 new request kept", {63'd0, stall}, 64'd1);
    fetchRsp(32'h0000_5004, 32'h8000_0002);
    fetch(32'h0000_5004, 1'b0);
    chk("R11 stale ignored", {63'd0, stall}, 64'd1);
    fetchRsp(32'h0000_5004, 32'h8000_0003);
    fetch(32'h0000_5004, 1'b0);
    chk("R11 released", {63'd0, stall}, 64'd0);

    // random phase against the model
    pc = 32'h0000_5004;
    held = 1'b0;
    for (int n = 0; n < 4000; n++) begin
      logic pv, fs, ce, cc, pl, rv;
      logic [3:0] pcyc;
      logic [31:0] rt;
      int sel;
      if (!held) begin
        r = $urandom_range(0, 9);
        if (r < 7) pc = pc + 4;
        else if (r < 9) pc = 32'h1000 + ($urandom_range(0, 255) << 2);
        else pc = pc + LB;
      end
      pv = ($urandom_range(0, 9) != 0);
      fs = ($urandom_range(0, 3) == 0);
      ce = ($urandom_range(0, 9) != 0);
      cc = ($urandom_range(0, 1) == 0);
      pl = ($urandom_range(0, 29) == 0);
      pcyc = 4'($urandom_range(0, 5));
      rv = 1'b0; rt = '0;
      r = $urandom_range(0, 9);
      if (r < 6 && pendN > 0) begin
        sel = $urandom_range(0, pendN - 1);
        rv = 1'b1; rt = pendTag[sel];
        for (int k = sel; k < pendN - 1; k++) pendTag[k] = pendTag[k+1];
        pendN--;
      end else if (r == 9) begin
        rv = 1'b1; rt = 32'h0000_5555;
      end
      step(pv, pc, fs, ce, cc, pl, pcyc, rv, rt);
      held = eStall;
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule